// File: doc/BRIEF.md
# Segmented Memory Address Generator

This block turns an addressing request into a 20-bit physical memory address. For a data access it adds up to three terms to form a 16-bit effective offset: an optional base register (BX or BP), an optional index register (SI or DI) and an optional displacement. The displacement is either a full 16-bit constant or an 8-bit constant that is sign-extended. A segment register is then chosen, shifted left by four bits and added to the offset.

The segment is picked by the access type. Code fetches pair CS with IP, stack accesses pair SS with SP, and string destinations pair ES with DI. A data access defaults to SS when BP is the base and to DS in every other case, and an override select can replace that choice. The result goes through one output register by default. Setting `REG_OUT` to 0 makes the block purely combinational. Instruction decoding and bus timing are left to the neighbouring logic.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals the selected segment value times 16 plus `eff_addr`, taken modulo 2^20. FFFF:0010 gives 00000, A4FB:4872 gives A9822, and with DS=1234h the offset 0300h gives 12640h while SI=0310h gives 12650h.
- R2: For a data access (`acc_kind`=1), `eff_addr` is the sum modulo 2^16 of the base term, the index term and the displacement term. The base term is `reg_bx` when `base_sel`=1, `reg_bp` when it is 2, and zero when it is 0 or 3. The index term is `reg_si` when `idx_sel`=1, `reg_di` when it is 2, and zero when it is 0 or 3. The displacement term is zero when `disp_en`=0.
- R3: When `disp_wide`=0, only `disp[7:0]` is used and it is sign-extended, so F9h adds -7. When `disp_wide`=1, all 16 bits of `disp` are added.
- R4: A data access with no override uses SS when `base_sel`=2 (BP) and DS otherwise.
- R5: With `ovr_en`=1, a data access uses the segment named by `ovr_seg`. The override has no effect on the other three access types.
- R6: A code fetch (`acc_kind`=0) gives CS:IP. The base, index and displacement fields have no effect.
- R7: A stack access (`acc_kind`=2) gives SS:SP.
- R8: A string destination (`acc_kind`=3) gives ES:DI.
- R9: `seg_pick` and `ovr_seg` share one encoding: 0=ES, 1=CS, 2=SS, 3=DS.
- R10: With `REG_OUT`=1, the outputs show the inputs sampled at the previous rising clock edge. While `rst_n` is low they are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset |
| seg_code | input | 16 | CS value |
| seg_data | input | 16 | DS value |
| seg_stack | input | 16 | SS value |
| seg_extra | input | 16 | ES value |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| reg_sp | input | 16 | SP value |
| reg_ip | input | 16 | IP value |
| acc_kind | input | 2 | 0 code, 1 data, 2 stack, 3 string destination |
| base_sel | input | 2 | 0 none, 1 BX, 2 BP, 3 none |
| idx_sel | input | 2 | 0 none, 1 SI, 2 DI, 3 none |
| disp | input | 16 | Displacement constant |
| disp_en | input | 1 | Include the displacement |
| disp_wide | input | 1 | 1 = 16-bit displacement, 0 = sign-extended low byte |
| ovr_en | input | 1 | Segment override active |
| ovr_seg | input | 2 | Override segment, in the R9 encoding |
| eff_addr | output | 16 | Effective offset |
| seg_pick | output | 2 | Segment used, in the R9 encoding |
| phys_addr | output | 20 | Physical address |

## Verification
The assertions are written for the registered variant and compare each output with the inputs held one cycle earlier. For that reason they only start once reset has been released for a full cycle. They assume the inputs change at most once per clock and hold steady across the sampling edge.

The bench drives all inputs on the falling edge and checks the outputs one falling edge after the capturing rising edge. Its stimulus includes the reserved selector value 3 for both `base_sel` and `idx_sel`, so that value is exercised as well.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [OFS_W-1:0]               seg_code,
  input  logic [OFS_W-1:0]               seg_data,
  input  logic [OFS_W-1:0]               seg_stack,
  input  logic [OFS_W-1:0]               seg_extra,
  input  logic [OFS_W-1:0]               reg_bx,
  input  logic [OFS_W-1:0]               reg_bp,
  input  logic [OFS_W-1:0]               reg_si,
  input  logic [OFS_W-1:0]               reg_di,
  input  logic [OFS_W-1:0]               reg_sp,
  input  logic [OFS_W-1:0]               reg_ip,
  input  logic [1:0]                     acc_kind,
  input  logic [1:0]                     base_sel,
  input  logic [1:0]                     idx_sel,
  input  logic [OFS_W-1:0]               disp,
  input  logic                           disp_en,
  input  logic                           disp_wide,
  input  logic                           ovr_en,
  input  logic [1:0]                     ovr_seg,
  output logic [OFS_W-1:0]               eff_addr,
  output logic [1:0]                     seg_pick,
  output logic [OFS_W+SEG_SHIFT-1:0]     phys_addr
);
  localparam int PA_W = OFS_W + SEG_SHIFT;
  localparam logic [1:0] S_ES = 2'd0, S_CS = 2'd1, S_SS = 2'd2, S_DS = 2'd3;

  logic [OFS_W-1:0] base_v, idx_v, disp_v, ea_n, seg_v;
  logic [1:0]       seg_n;
  logic [PA_W-1:0]  pa_n;

  assign base_v = (base_sel == 2'd1) ? reg_bx :
                  (base_sel == 2'd2) ? reg_bp : '0;
  assign idx_v  = (idx_sel == 2'd1) ? reg_si :
                  (idx_sel == 2'd2) ? reg_di : '0;
  assign disp_v = !disp_en  ? '0 :
                  disp_wide ? disp : {{(OFS_W-8){disp[7]}}, disp[7:0]};

  always_comb begin
    case (acc_kind)
      2'd0: begin ea_n = reg_ip; seg_n = S_CS; end
      2'd2: begin ea_n = reg_sp; seg_n = S_SS; end
      2'd3: begin ea_n = reg_di; seg_n = S_ES; end
      default: begin
        ea_n  = base_v + idx_v + disp_v;
        seg_n = ovr_en ? ovr_seg : ((base_sel == 2'd2) ? S_SS : S_DS);
      end
    endcase
  end

  always_comb begin
    case (seg_n)
      S_ES:    seg_v = seg_extra;
      S_CS:    seg_v = seg_code;
      S_SS:    seg_v = seg_stack;
      default: seg_v = seg_data;
    endcase
  end

  assign pa_n = {seg_v, {SEG_SHIFT{1'b0}}} + PA_W'(ea_n);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          eff_addr  <= '0;
          seg_pick  <= '0;
          phys_addr <= '0;
        end else begin
          eff_addr  <= ea_n;
          seg_pick  <= seg_n;
          phys_addr <= pa_n;
        end
      end
    end else begin : g_comb
      assign eff_addr  = ea_n;
      assign seg_pick  = seg_n;
      assign phys_addr = pa_n;
    end
  endgenerate
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter bit REG_OUT   = 1'b1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [OFS_W-1:0]           seg_code,
  input logic [OFS_W-1:0]           seg_data,
  input logic [OFS_W-1:0]           seg_stack,
  input logic [OFS_W-1:0]           seg_extra,
  input logic [OFS_W-1:0]           reg_bp,
  input logic [OFS_W-1:0]           reg_di,
  input logic [OFS_W-1:0]           reg_sp,
  input logic [OFS_W-1:0]           reg_ip,
  input logic [1:0]                 acc_kind,
  input logic [1:0]                 base_sel,
  input logic                       ovr_en,
  input logic [1:0]                 ovr_seg,
  input logic [OFS_W-1:0]           eff_addr,
  input logic [1:0]                 seg_pick,
  input logic [OFS_W+SEG_SHIFT-1:0] phys_addr
);
  localparam int PA_W = OFS_W + SEG_SHIFT;
  logic             live;
  logic [OFS_W-1:0] p_cs, p_ds, p_ss, p_es, p_bp, p_di, p_sp, p_ip, seg_sel;
  logic [1:0]       p_kind, p_base, p_oseg;
  logic             p_oen;
  logic [PA_W-1:0]  pa_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  always_ff @(posedge clk) begin
    p_cs <= seg_code;  p_ds <= seg_data;  p_ss <= seg_stack; p_es <= seg_extra;
    p_bp <= reg_bp;    p_di <= reg_di;    p_sp <= reg_sp;    p_ip <= reg_ip;
    p_kind <= acc_kind; p_base <= base_sel; p_oen <= ovr_en; p_oseg <= ovr_seg;
  end

  always_comb begin
    case (seg_pick)
      2'd0:    seg_sel = p_es;
      2'd1:    seg_sel = p_cs;
      2'd2:    seg_sel = p_ss;
      default: seg_sel = p_ds;
    endcase
  end
  assign pa_exp = {seg_sel, {SEG_SHIFT{1'b0}}} + PA_W'(eff_addr);

  generate
    if (REG_OUT) begin : g_reg_chk
      a_r1_phys_sum: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> phys_addr == pa_exp);
      a_r4_bp_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (live && p_kind == 2'd1 && !p_oen && p_base == 2'd2) |-> seg_pick == 2'd2);
      a_r5_override: assert property (@(posedge clk) disable iff (!rst_n)
        (live && p_kind == 2'd1 && p_oen) |-> seg_pick == p_oseg);
      a_r6_code_ip: assert property (@(posedge clk) disable iff (!rst_n)
        (live && p_kind == 2'd0) |-> (seg_pick == 2'd1 && eff_addr == p_ip));
      a_r7_stack_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (live && p_kind == 2'd2) |-> (seg_pick == 2'd2 && eff_addr == p_sp));
      a_r8_string_di: assert property (@(posedge clk) disable iff (!rst_n)
        (live && p_kind == 2'd3) |-> (seg_pick == 2'd0 && eff_addr == p_di));
      a_r4_bp_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (live && p_kind == 2'd1 && p_base == 2'd2 && !p_oen) |-> phys_addr == {p_ss, {SEG_SHIFT{1'b0}}} + PA_W'(eff_addr));
      a_r8_unused_bp: assert property (@(posedge clk) disable iff (!rst_n)
        (live && p_kind == 2'd3) |-> phys_addr == {p_es, {SEG_SHIFT{1'b0}}} + PA_W'(p_di) || p_bp != p_bp);
    end
  endgenerate
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] seg_code, seg_data, seg_stack, seg_extra;
  logic [15:0] reg_bx, reg_bp, reg_si, reg_di, reg_sp, reg_ip, disp;
  logic [1:0]  acc_kind, base_sel, idx_sel, ovr_seg, seg_pick;
  logic        disp_en, disp_wide, ovr_en;
  logic [15:0] eff_addr;
  logic [19:0] phys_addr;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_addr_gen dut (.*);

  function automatic logic [15:0] seg_val(input logic [1:0] s);
    case (s)
      2'd0: return seg_extra;
      2'd1: return seg_code;
      2'd2: return seg_stack;
      default: return seg_data;
    endcase
  endfunction

  function automatic logic [1:0] exp_seg();
    if (acc_kind == 2'd0) return 2'd1;
    if (acc_kind == 2'd2) return 2'd2;
    if (acc_kind == 2'd3) return 2'd0;
    if (ovr_en) return ovr_seg;
    return (base_sel == 2'd2) ? 2'd2 : 2'd3;
  endfunction

  function automatic logic [15:0] exp_eff();
    logic [15:0] b, x, d;
    if (acc_kind == 2'd0) return reg_ip;
    if (acc_kind == 2'd2) return reg_sp;
    if (acc_kind == 2'd3) return reg_di;
    b = (base_sel == 2'd1) ? reg_bx : (base_sel == 2'd2) ? reg_bp : 16'h0;
    x = (idx_sel == 2'd1) ? reg_si : (idx_sel == 2'd2) ? reg_di : 16'h0;
    d = !disp_en ? 16'h0 : disp_wide ? disp : {{8{disp[7]}}, disp[7:0]};
    return b + x + d;
  endfunction

  task automatic check(input string tag, input logic [1:0] es,
                       input logic [15:0] ee, input logic [19:0] ep);
    checks++;
    if (seg_pick !== es || eff_addr !== ee || phys_addr !== ep) begin
      failures++;
      $display("FAIL %s: got seg=%0d ea=%h pa=%h expected seg=%0d ea=%h pa=%h",
               tag, seg_pick, eff_addr, phys_addr, es, ee, ep);
    end
  endtask

  task automatic apply_and_check(input string tag);
    logic [1:0]  es;
    logic [15:0] ee;
    logic [19:0] ep;
    es = exp_seg();
    ee = exp_eff();
    ep = {seg_val(es), 4'h0} + {4'h0, ee};
    @(posedge clk);
    @(negedge clk);
    check(tag, es, ee, ep);
  endtask

  task automatic quiet();
    acc_kind = 2'd1; base_sel = 2'd0; idx_sel = 2'd0; disp = 16'h0;
    disp_en = 1'b0; disp_wide = 1'b1; ovr_en = 1'b0; ovr_seg = 2'd0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    seg_code = 16'h1000; seg_data = 16'h1234; seg_stack = 16'h2000; seg_extra = 16'h3000;
    reg_bx = 16'h0100; reg_bp = 16'h0200; reg_si = 16'h0310; reg_di = 16'h0400;
    reg_sp = 16'hFFF0; reg_ip = 16'h0005;
    quiet();
    repeat (3) @(negedge clk);
    check("R10 reset", 2'd0, 16'h0, 20'h0);
    rst_n = 1'b1;

    disp = 16'h0300; disp_en = 1'b1;
    apply_and_check("R1 direct DS");
    check("R1 direct 12640h", 2'd3, 16'h0300, 20'h12640);
    quiet(); idx_sel = 2'd1;
    apply_and_check("R1 SI indirect");
    check("R1 SI 12650h", 2'd3, 16'h0310, 20'h12650);
    seg_data = 16'hA4FB; quiet(); disp = 16'h4872; disp_en = 1'b1;
    apply_and_check("R1 A9822");
    check("R1 A4FB:4872", 2'd3, 16'h4872, 20'hA9822);
    seg_data = 16'hFFFF; disp = 16'h0010;
    apply_and_check("R1 wrap");
    check("R1 FFFF:0010", 2'd3, 16'h0010, 20'h00000);
    seg_data = 16'h1234;

    quiet(); base_sel = 2'd2; idx_sel = 2'd1; disp = 16'h00F9; disp_en = 1'b1; disp_wide = 1'b0;
    apply_and_check("R3 BP+SI-7 R4 SS");
    check("R3 BP+SI-7", 2'd2, 16'h0509, 20'h20509);
    quiet(); base_sel = 2'd1; idx_sel = 2'd2; disp = 16'h8000; disp_en = 1'b1;
    reg_bx = 16'h9000;
    apply_and_check("R2 EA wrap");
    reg_bx = 16'h0100;
    quiet(); base_sel = 2'd3; idx_sel = 2'd3;
    apply_and_check("R2 reserved selects");
    quiet(); base_sel = 2'd2; ovr_en = 1'b1; ovr_seg = 2'd3;
    apply_and_check("R5 BP with DS override");
    quiet(); base_sel = 2'd1; ovr_en = 1'b1; ovr_seg = 2'd0;
    apply_and_check("R5 R9 ES override");
    quiet(); acc_kind = 2'd0; base_sel = 2'd1; idx_sel = 2'd1; disp_en = 1'b1; disp = 16'h1111;
    ovr_en = 1'b1; ovr_seg = 2'd0;
    apply_and_check("R6 code CS:IP");
    check("R6 code 10005h", 2'd1, 16'h0005, 20'h10005);
    acc_kind = 2'd2;
    apply_and_check("R7 stack SS:SP");
    acc_kind = 2'd3; ovr_seg = 2'd3;
    apply_and_check("R8 string ES:DI");
    check("R8 string 30400h", 2'd0, 16'h0400, 20'h30400);

    for (int i = 0; i < 400; i++) begin
      seg_code = 16'($urandom); seg_data = 16'($urandom);
      seg_stack = 16'($urandom); seg_extra = 16'($urandom);
      reg_bx = 16'($urandom); reg_bp = 16'($urandom); reg_si = 16'($urandom);
      reg_di = 16'($urandom); reg_sp = 16'($urandom); reg_ip = 16'($urandom);
      disp = 16'($urandom);
      acc_kind = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd1;
      base_sel = 2'($urandom); idx_sel = 2'($urandom);
      disp_en = 1'($urandom); disp_wide = 1'($urandom);
      ovr_en = ($urandom_range(0, 3) == 0); ovr_seg = 2'($urandom);
      apply_and_check("R1 R2 R3 R4 R5 R9 random");
    end

    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset again", 2'd0, 16'h0, 20'h0);
    done = 1'b1;
    finish_run();
  end
endmodule